// File: doc/BRIEF.md
# Interrupt Vector and State-Save Unit

This unit handles the entry into and the return from interrupts for a 32-bit embedded core. Software programs a 16-bit vector prefix and one 12-bit handler offset for each interrupt cause. It does this through a write port into the special-register space. When one or more cause requests are present, the unit chooses one request that is enabled by the machine-state register. It then forms the handler fetch address by concatenation, and issues a one-cycle redirect. It saves the resume address and the prior machine state into the save pair that belongs to the cause's class: base, critical or debug.

On entry the unit also loads the exception syndrome register, the fault-address register and the machine-check syndrome register, but only for the causes that define them. It clears the enable bits so that the saved pair cannot be overwritten. Three return strobes, one per class, restore the machine state from the matching pair and redirect to the saved address. The prefix and offset registers have no reset value, so software must write them before it enables any interrupt.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, taken_o and redirect_o are low. The machine state, all six save registers and the esr, dear and mcsr registers read zero.
- R2: A write to special address 0x01 stores wdata[31:16] as the prefix. A write to 0x40+index stores wdata[15:4] as the offset for that cause index. One cycle after an accepted request, taken_o and redirect_o are high for one cycle, and target_o = {prefix, offset, 4'b0000}.
- R3: Request bit k selects cause index k for k = 0..7 and 10..15. Bit 8 selects index 32 and bit 9 selects index 33. cause_o reports the index of the accepted request.
- R4: When several enabled requests are present, the unit accepts them in this order: bit 1 (machine check), bit 15 (debug), bit 0 (critical input), bit 12 (watchdog), then the remaining bits with the lowest bit first.
- R5: Machine-state enable bits: bit 12 gates machine check, bit 9 gates debug, bit 17 gates bits 0 and 12, and bit 15 gates every other cause. A request whose enable is clear is ignored.
- R6: A critical-class entry (bits 0, 1, 12) stores epc_i in csrr0 and the prior machine state in csrr1. It clears machine-state bits 12, 15 and 17.
- R7: A debug entry (bit 15) stores epc_i in dsrr0 and the prior machine state in dsrr1. It clears machine-state bits 9, 15 and 17.
- R8: A base-class entry stores epc_i in srr0 and the prior machine state in srr1. It clears machine-state bit 15.
- R9: Entries for bits 2, 3, 5, 6, 7, 8, 9, 13 and 14 replace esr with syn_i in full. Entries for any other cause leave esr unchanged.
- R10: Entries for bits 2, 5 and 13 load dear with fault_addr_i. Entries for any other cause leave dear unchanged.
- R11: A machine-check entry loads mcsr with mcsyn_i.
- R12: When no request is accepted, a return strobe restores the machine state from its pair's register 1. One cycle later redirect_o is high, taken_o is low and target_o equals register 0. If several return strobes are present, debug wins over critical and critical wins over base. An accepted request in the same cycle wins, and the return is ignored.
- R13: A write to special address 0x02 loads the machine state, unless an entry or a return occurs in the same cycle. Writes to reserved offset indices change no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_we_i | input | 1 | Special-register write strobe |
| spr_addr_i | input | 7 | Special-register address |
| spr_wdata_i | input | 32 | Special-register write data |
| req_i | input | 16 | Cause request lines |
| epc_i | input | 32 | Resume address to save on entry |
| syn_i | input | 32 | Exception syndrome value |
| mcsyn_i | input | 32 | Machine-check syndrome value |
| fault_addr_i | input | 32 | Faulting data effective address |
| ret_base_i | input | 1 | Base-class return |
| ret_crit_i | input | 1 | Critical-class return |
| ret_dbg_i | input | 1 | Debug return |
| taken_o | output | 1 | Interrupt entered (pulse) |
| redirect_o | output | 1 | Fetch redirect valid (pulse) |
| target_o | output | 32 | Redirect address |
| cause_o | output | 6 | Cause index of last entry |
| msr_o | output | 32 | Machine state |
| srr0_o | output | 32 | Base save address |
| srr1_o | output | 32 | Base saved state |
| csrr0_o | output | 32 | Critical save address |
| csrr1_o | output | 32 | Critical saved state |
| dsrr0_o | output | 32 | Debug save address |
| dsrr1_o | output | 32 | Debug saved state |
| esr_o | output | 32 | Exception syndrome |
| dear_o | output | 32 | Fault address |
| mcsr_o | output | 32 | Machine-check syndrome |

## Verification
The bench builds the unit with its default parameters: a 16-bit prefix, a 12-bit offset and a 7-bit special address. These give full 32-bit handler addresses. They also give an offset window wide enough to reach indices 32 and 33 as well as the reserved index 8, so the remapped request bits and the write to a reserved slot can both be checked at the ports. Each of the 16 offsets is programmed with a distinct value, so any wrong choice among simultaneous requests appears directly in target_o.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int N_CAUSE = 16;
  localparam int IDX_W   = 6;
  localparam int SEL_W   = $clog2(N_CAUSE);

  // machine-state enable bit positions
  localparam int MSR_DE = 9;
  localparam int MSR_ME = 12;
  localparam int MSR_EE = 15;
  localparam int MSR_CE = 17;

  // request bit positions with fixed priority
  localparam int C_CRIT = 0;
  localparam int C_MCHK = 1;
  localparam int C_WDOG = 12;
  localparam int C_DBG  = 15;

  localparam logic [N_CAUSE-1:0] SYN_MASK  = 16'h63EC;
  localparam logic [N_CAUSE-1:0] DEAR_MASK = 16'h2024;

  localparam int SPR_PFX  = 'h01;
  localparam int SPR_MSR  = 'h02;
  localparam int SPR_OFS0 = 'h40;

  typedef enum logic [1:0] {CLS_BASE, CLS_CRIT, CLS_DBG} cls_e;

  function automatic logic [IDX_W-1:0] cause_idx(input int k);
    if (k == 8) return IDX_W'(32);
    if (k == 9) return IDX_W'(33);
    return IDX_W'(k);
  endfunction

  function automatic cls_e cause_cls(input int k);
    if (k == C_DBG) return CLS_DBG;
    if (k == C_MCHK || k == C_CRIT || k == C_WDOG) return CLS_CRIT;
    return CLS_BASE;
  endfunction
endpackage

// File: rtl/ivu_pick.sv
module ivu_pick
  import ivu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] req_i,
  input  logic               en_base_i,
  input  logic               en_crit_i,
  input  logic               en_mchk_i,
  input  logic               en_dbg_i,
  output logic               valid_o,
  output logic [SEL_W-1:0]   sel_o,
  output cls_e               cls_o
);
  logic [N_CAUSE-1:0] gated;
  logic [N_CAUSE-1:0] pick_oh;

  for (genvar k = 0; k < N_CAUSE; k++) begin : g_gate
    if (k == C_MCHK) begin : g_m
      assign gated[k] = req_i[k] & en_mchk_i;
    end else if (k == C_DBG) begin : g_d
      assign gated[k] = req_i[k] & en_dbg_i;
    end else if (k == C_CRIT || k == C_WDOG) begin : g_c
      assign gated[k] = req_i[k] & en_crit_i;
    end else begin : g_b
      assign gated[k] = req_i[k] & en_base_i;
    end
  end

  always_comb begin
    valid_o = |gated;
    sel_o   = '0;
    if (gated[C_MCHK])      sel_o = SEL_W'(C_MCHK);
    else if (gated[C_DBG])  sel_o = SEL_W'(C_DBG);
    else if (gated[C_CRIT]) sel_o = SEL_W'(C_CRIT);
    else if (gated[C_WDOG]) sel_o = SEL_W'(C_WDOG);
    else begin
      for (int k = N_CAUSE - 1; k >= 0; k--)
        if (gated[k]) sel_o = SEL_W'(k);
    end
    cls_o   = cause_cls(int'(sel_o));
    pick_oh = valid_o ? (N_CAUSE'(1) << sel_o) : '0;
  end

  // R4
  pick_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_oh) && ((pick_oh & ~req_i) == '0));
  // R5
  base_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_base_i |-> !(valid_o && cls_o == CLS_BASE));
  // R5
  dbg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_dbg_i |-> !(valid_o && cls_o == CLS_DBG));
endmodule

// File: rtl/ivu_vtab.sv
module ivu_vtab
  import ivu_pkg::*;
#(
  parameter int PFX_W  = 16,
  parameter int OFS_W  = 12,
  parameter int SPR_AW = 7,
  localparam int ALN_W = 4,
  localparam int XLEN  = PFX_W + OFS_W + ALN_W
) (
  input  logic              clk_i,
  input  logic              spr_we_i,
  input  logic [SPR_AW-1:0] spr_addr_i,
  input  logic [XLEN-1:0]   spr_wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [XLEN-1:0]   target_o
);
  logic [PFX_W-1:0]                pfx_q;
  logic [N_CAUSE-1:0][OFS_W-1:0]   ofs_q;
  logic                            unused_lo;

  assign unused_lo = ^spr_wdata_i[ALN_W-1:0];

  // no reset: software must program before use
  always_ff @(posedge clk_i)
    if (spr_we_i && spr_addr_i == SPR_AW'(SPR_PFX))
      pfx_q <= spr_wdata_i[XLEN-1 -: PFX_W];

  for (genvar k = 0; k < N_CAUSE; k++) begin : g_slot
    localparam logic [SPR_AW-1:0] SLOT_A = SPR_AW'(SPR_OFS0 + int'(cause_idx(k)));
    logic [OFS_W-1:0] slot_q;
    always_ff @(posedge clk_i)
      if (spr_we_i && spr_addr_i == SLOT_A)
        slot_q <= spr_wdata_i[ALN_W +: OFS_W];
    assign ofs_q[k] = slot_q;
  end

  assign target_o = {pfx_q, ofs_q[sel_i], {ALN_W{1'b0}}};
endmodule

// File: rtl/ivu_state.sv
module ivu_state
  import ivu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int SPR_AW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_i,
  input  cls_e              cls_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [XLEN-1:0]   vec_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   syn_i,
  input  logic [XLEN-1:0]   mcsyn_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic              ret_base_i,
  input  logic              ret_crit_i,
  input  logic              ret_dbg_i,
  input  logic              spr_we_i,
  input  logic [SPR_AW-1:0] spr_addr_i,
  input  logic [XLEN-1:0]   spr_wdata_i,
  output logic              taken_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic [IDX_W-1:0]  cause_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   csrr0_o,
  output logic [XLEN-1:0]   csrr1_o,
  output logic [XLEN-1:0]   dsrr0_o,
  output logic [XLEN-1:0]   dsrr1_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   dear_o,
  output logic [XLEN-1:0]   mcsr_o
);
  logic            taken_q, redir_q;
  logic [XLEN-1:0] tgt_q, msr_q, srr0_q, srr1_q, csrr0_q, csrr1_q, dsrr0_q, dsrr1_q;
  logic [XLEN-1:0] esr_q, dear_q, mcsr_q;
  logic [IDX_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0; redir_q <= 1'b0; tgt_q <= '0; cause_q <= '0;
      msr_q <= '0; srr0_q <= '0; srr1_q <= '0; csrr0_q <= '0; csrr1_q <= '0;
      dsrr0_q <= '0; dsrr1_q <= '0; esr_q <= '0; dear_q <= '0; mcsr_q <= '0;
    end else begin
      taken_q <= 1'b0;
      redir_q <= 1'b0;
      if (ent_i) begin
        taken_q <= 1'b1;
        redir_q <= 1'b1;
        tgt_q   <= vec_i;
        cause_q <= cause_idx(int'(sel_i));
        unique case (cls_i)
          CLS_CRIT: begin
            csrr0_q <= epc_i;
            csrr1_q <= msr_q;
            msr_q[MSR_ME] <= 1'b0;
            msr_q[MSR_CE] <= 1'b0;
            msr_q[MSR_EE] <= 1'b0;
            if (sel_i == SEL_W'(C_MCHK)) mcsr_q <= mcsyn_i;
          end
          CLS_DBG: begin
            dsrr0_q <= epc_i;
            dsrr1_q <= msr_q;
            msr_q[MSR_DE] <= 1'b0;
            msr_q[MSR_CE] <= 1'b0;
            msr_q[MSR_EE] <= 1'b0;
          end
          default: begin
            srr0_q <= epc_i;
            srr1_q <= msr_q;
            msr_q[MSR_EE] <= 1'b0;
            if (SYN_MASK[sel_i])  esr_q  <= syn_i;
            if (DEAR_MASK[sel_i]) dear_q <= fault_addr_i;
          end
        endcase
      end else if (ret_dbg_i) begin
        msr_q <= dsrr1_q; redir_q <= 1'b1; tgt_q <= dsrr0_q;
      end else if (ret_crit_i) begin
        msr_q <= csrr1_q; redir_q <= 1'b1; tgt_q <= csrr0_q;
      end else if (ret_base_i) begin
        msr_q <= srr1_q;  redir_q <= 1'b1; tgt_q <= srr0_q;
      end else if (spr_we_i && spr_addr_i == SPR_AW'(SPR_MSR)) begin
        msr_q <= spr_wdata_i;
      end
    end
  end

  assign taken_o = taken_q;   assign redirect_o = redir_q;
  assign target_o = tgt_q;    assign cause_o = cause_q;
  assign msr_o = msr_q;       assign srr0_o = srr0_q;   assign srr1_o = srr1_q;
  assign csrr0_o = csrr0_q;   assign csrr1_o = csrr1_q;
  assign dsrr0_o = dsrr0_q;   assign dsrr1_o = dsrr1_q;
  assign esr_o = esr_q;       assign dear_o = dear_q;   assign mcsr_o = mcsr_q;

  // R8
  base_ee_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_i && cls_i == CLS_BASE) |=> !msr_q[MSR_EE] && srr1_q == $past(msr_q));
  // R6
  crit_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_i && cls_i == CLS_CRIT) |=> csrr1_q == $past(msr_q) && !msr_q[MSR_CE]);
  // R7
  dbg_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_i && cls_i == CLS_DBG) |=> dsrr1_q == $past(msr_q) && !msr_q[MSR_DE]);
  // R12
  ret_base_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ent_i && ret_base_i && !ret_crit_i && !ret_dbg_i) |=> msr_q == $past(srr1_q) && !taken_q);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int PFX_W  = 16,
  parameter int OFS_W  = 12,
  parameter int SPR_AW = 7,
  localparam int XLEN  = PFX_W + OFS_W + 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               spr_we_i,
  input  logic [SPR_AW-1:0]  spr_addr_i,
  input  logic [XLEN-1:0]    spr_wdata_i,
  input  logic [N_CAUSE-1:0] req_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [XLEN-1:0]    syn_i,
  input  logic [XLEN-1:0]    mcsyn_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  input  logic               ret_base_i,
  input  logic               ret_crit_i,
  input  logic               ret_dbg_i,
  output logic               taken_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_o,
  output logic [IDX_W-1:0]   cause_o,
  output logic [XLEN-1:0]    msr_o,
  output logic [XLEN-1:0]    srr0_o,
  output logic [XLEN-1:0]    srr1_o,
  output logic [XLEN-1:0]    csrr0_o,
  output logic [XLEN-1:0]    csrr1_o,
  output logic [XLEN-1:0]    dsrr0_o,
  output logic [XLEN-1:0]    dsrr1_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    dear_o,
  output logic [XLEN-1:0]    mcsr_o
);
  logic             ent;
  logic [SEL_W-1:0] sel;
  cls_e             cls;
  logic [XLEN-1:0]  vec;

  ivu_pick u_pick (
    .clk_i, .rst_ni, .req_i,
    .en_base_i (msr_o[MSR_EE]),
    .en_crit_i (msr_o[MSR_CE]),
    .en_mchk_i (msr_o[MSR_ME]),
    .en_dbg_i  (msr_o[MSR_DE]),
    .valid_o   (ent),
    .sel_o     (sel),
    .cls_o     (cls)
  );

  ivu_vtab #(.PFX_W(PFX_W), .OFS_W(OFS_W), .SPR_AW(SPR_AW)) u_vtab (
    .clk_i, .spr_we_i, .spr_addr_i, .spr_wdata_i,
    .sel_i    (sel),
    .target_o (vec)
  );

  ivu_state #(.XLEN(XLEN), .SPR_AW(SPR_AW)) u_state (
    .clk_i, .rst_ni,
    .ent_i (ent), .cls_i (cls), .sel_i (sel), .vec_i (vec),
    .epc_i, .syn_i, .mcsyn_i, .fault_addr_i,
    .ret_base_i, .ret_crit_i, .ret_dbg_i,
    .spr_we_i, .spr_addr_i, .spr_wdata_i,
    .taken_o, .redirect_o, .target_o, .cause_o, .msr_o,
    .srr0_o, .srr1_o, .csrr0_o, .csrr1_o, .dsrr0_o, .dsrr1_o,
    .esr_o, .dear_o, .mcsr_o
  );
endmodule

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        spr_we = 1'b0;
  logic [6:0]  spr_addr = '0;
  logic [31:0] spr_wdata = '0, epc = '0, syn = '0, mcsyn = '0, fault = '0;
  logic [15:0] req = '0;
  logic        ret_b = 1'b0, ret_c = 1'b0, ret_d = 1'b0;
  logic        taken, redir;
  logic [31:0] target, msr, srr0, srr1, csrr0, csrr1, dsrr0, dsrr1, esr, dear, mcsr;
  logic [5:0]  cause;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spr_we_i(spr_we), .spr_addr_i(spr_addr),
    .spr_wdata_i(spr_wdata), .req_i(req), .epc_i(epc), .syn_i(syn), .mcsyn_i(mcsyn),
    .fault_addr_i(fault), .ret_base_i(ret_b), .ret_crit_i(ret_c), .ret_dbg_i(ret_d),
    .taken_o(taken), .redirect_o(redir), .target_o(target), .cause_o(cause),
    .msr_o(msr), .srr0_o(srr0), .srr1_o(srr1), .csrr0_o(csrr0), .csrr1_o(csrr1),
    .dsrr0_o(dsrr0), .dsrr1_o(dsrr1), .esr_o(esr), .dear_o(dear), .mcsr_o(mcsr)
  );

  localparam logic [31:0] EN_ALL = 32'h29200;
  localparam logic [31:0] EN_EE  = 32'h08000;
  // {req, msr, expect taken, expect cause index}
  localparam int NV = 10;
  localparam logic [54:0] VEC [NV] = '{
    {16'hFFFF, EN_ALL,       1'b1, 6'd1},
    {16'hFFFF, 32'h28200,    1'b1, 6'd15},
    {16'hFFFF, 32'h28000,    1'b1, 6'd0},
    {16'h1010, 32'h28000,    1'b1, 6'd12},
    {16'h0050, EN_EE,        1'b1, 6'd4},
    {16'h4200, EN_EE,        1'b1, 6'd33},
    {16'h0100, EN_EE,        1'b1, 6'd32},
    {16'hFFFF, 32'h0,        1'b0, 6'd0},
    {16'h9003, EN_EE,        1'b0, 6'd0},
    {16'h0004, EN_EE,        1'b1, 6'd2}
  };

  function automatic logic [5:0] b_idx(input int k);
    return (k == 8) ? 6'd32 : (k == 9) ? 6'd33 : 6'(k);
  endfunction

  function automatic logic [31:0] exp_vec(input logic [5:0] idx);
    return {16'hABCD, 12'h100 + 12'(idx), 4'h0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic spr_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    spr_we = 1'b1; spr_addr = a; spr_wdata = d;
    @(posedge clk); @(negedge clk);
    spr_we = 1'b0;
  endtask

  // one cycle of stimulus; returns at the negedge after the capturing edge
  task automatic step(input logic [15:0] r, input logic [31:0] pc, input logic [31:0] s,
                      input logic [31:0] mc, input logic [31:0] fa,
                      input logic rb, input logic rc, input logic rd,
                      input logic we, input logic [31:0] wd);
    @(negedge clk);
    req = r; epc = pc; syn = s; mcsyn = mc; fault = fa;
    ret_b = rb; ret_c = rc; ret_d = rd;
    spr_we = we; spr_addr = 7'h02; spr_wdata = wd;
    @(posedge clk); @(negedge clk);
    req = '0; ret_b = 1'b0; ret_c = 1'b0; ret_d = 1'b0; spr_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 taken", 32'(taken), 32'h0);
    chk("R1 redirect", 32'(redir), 32'h0);
    chk("R1 msr", msr, 32'h0);
    chk("R1 srr0", srr0, 32'h0);
    chk("R1 esr", esr, 32'h0);
    chk("R1 mcsr", mcsr, 32'h0);
    rst_n = 1'b1;

    spr_wr(7'h01, 32'hABCD_1234);
    for (int k = 0; k < 16; k++)
      spr_wr(7'h40 + 7'(b_idx(k)), {16'h0, 12'h100 + 12'(b_idx(k)), 4'h0});

    // R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      automatic logic [54:0] v = VEC[i];
      spr_wr(7'h02, v[38:7]);
      step(v[54:39], 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0);
      chk($sformatf("R5 taken vec%0d", i), 32'(taken), 32'(v[6]));
      if (v[6]) begin
        chk($sformatf("R4 cause vec%0d", i), 32'(cause), 32'(v[5:0]));
        chk($sformatf("R2 target vec%0d", i), target, exp_vec(v[5:0]));
      end
    end

    // R8 base entry
    spr_wr(7'h02, EN_EE);
    step(16'h0010, 32'h1000, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R8 srr0", srr0, 32'h1000);
    chk("R8 srr1", srr1, EN_EE);
    chk("R8 msr", msr, 32'h0);
    chk("R2 redirect", 32'(redir), 32'h1);
    @(negedge clk);
    chk("R2 taken pulse ends", 32'(taken), 32'h0);

    // R9 R10 syndrome and fault address
    spr_wr(7'h02, EN_EE);
    step(16'h0020, 32'h0, 32'h0080_0000, 32'h0, 32'hDEAD_0004, 0, 0, 0, 0, 32'h0);
    chk("R9 esr align", esr, 32'h0080_0000);
    chk("R10 dear align", dear, 32'hDEAD_0004);
    spr_wr(7'h02, EN_EE);
    step(16'h0010, 32'h0, 32'h0000_FFFF, 32'h0, 32'h1, 0, 0, 0, 0, 32'h0);
    chk("R9 esr kept on external", esr, 32'h0080_0000);
    chk("R10 dear kept on external", dear, 32'hDEAD_0004);
    spr_wr(7'h02, EN_EE);
    step(16'h0040, 32'h0, 32'h0800_0000, 32'h0, 32'h5, 0, 0, 0, 0, 32'h0);
    chk("R9 esr program", esr, 32'h0800_0000);
    chk("R10 dear kept on program", dear, 32'hDEAD_0004);

    // R6 critical entry, R12 critical return
    spr_wr(7'h02, 32'h29000);
    step(16'h1000, 32'h2000, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R6 csrr0", csrr0, 32'h2000);
    chk("R6 csrr1", csrr1, 32'h29000);
    chk("R6 msr", msr, 32'h0);
    step(16'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 1, 0, 0, 32'h0);
    chk("R12 crit msr", msr, 32'h29000);
    chk("R12 crit target", target, 32'h2000);
    chk("R12 crit taken low", 32'(taken), 32'h0);
    chk("R12 crit redirect", 32'(redir), 32'h1);

    // R11 machine check
    step(16'h0002, 32'h3000, 32'h0, 32'h5, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R11 mcsr", mcsr, 32'h5);
    chk("R11 csrr0", csrr0, 32'h3000);

    // R7 debug entry and return
    spr_wr(7'h02, EN_ALL);
    step(16'h8000, 32'h4000, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R7 dsrr0", dsrr0, 32'h4000);
    chk("R7 dsrr1", dsrr1, EN_ALL);
    chk("R7 msr", msr, 32'h1000);
    step(16'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    chk("R12 dbg msr", msr, EN_ALL);
    chk("R12 dbg target", target, 32'h4000);

    // R12 entry wins over a return in the same cycle
    spr_wr(7'h02, EN_EE);
    step(16'h0010, 32'h5000, 32'h0, 32'h0, 32'h0, 1, 0, 0, 0, 32'h0);
    chk("R12 entry wins taken", 32'(taken), 32'h1);
    chk("R12 entry wins msr", msr, 32'h0);
    step(16'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1, 0, 0, 0, 32'h0);
    chk("R12 base msr", msr, EN_EE);
    chk("R12 base target", target, 32'h5000);

    // R12 debug return beats base return
    step(16'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1, 0, 1, 0, 32'h0);
    chk("R12 ret priority msr", msr, EN_ALL);
    chk("R12 ret priority target", target, 32'h4000);

    // R13 state write dropped during entry
    spr_wr(7'h02, EN_EE);
    step(16'h0010, 32'h6000, 32'h0, 32'h0, 32'h0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R13 write dropped on entry", msr, 32'h0);
    // R13 reserved offset slot write has no effect
    spr_wr(7'h48, 32'h0000_FFF0);
    spr_wr(7'h02, EN_EE);
    step(16'h0100, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 0, 32'h0);
    chk("R13 reserved slot ignored", target, exp_vec(6'd32));
    chk("R3 cause bit8", 32'(cause), 32'd32);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule